// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

This block buffers 36-bit words that arrive on a write port clocked by `wr_clk` and hands them out on a read port clocked by `rd_clk`. The two clocks may be unrelated or the same. Every transfer happens on the rising edge of its own port clock, and only while that port's enable is high. Data moves one way only, from the write port to the read port.

The read port can return each stored word whole, as two 18-bit pieces, or as four 9-bit pieces. Narrow pieces come out big-endian, most significant piece first, or little-endian, least significant piece first. Two threshold flags warn that the buffer is close to empty or close to full. Their offsets are chosen at full reset. A partial reset empties the buffer and keeps every setting that was in place.

The width, endian and offset selects are taken only while full reset is held. Both reset inputs are synchronous and active-low. Each must be held for at least four cycles of the slower clock, so that both clock domains see it.

Top module: `bmf_top`

## Requirements
- R1: A word presented with `wr_en` high while `wr_full` is low is stored on the rising edge of `wr_clk`. With width code 2'b00 (also used for code 2'b11), words leave on `rd_data[35:0]` in the order they were written. The read takes effect on the `rd_clk` edge where `rd_en` is high and `rd_empty` is low, and data is valid after that edge.
- R2: With width code 2'b01 and `cfg_big_endian`=1, each word is read as two pieces on `rd_data[17:0]`: bits [35:18] first, then bits [17:0]. `rd_data[35:18]` reads zero.
- R3: With width code 2'b10, each word is read as four pieces on `rd_data[8:0]`, with `rd_data[35:9]` zero. Big-endian order is [35:27], [26:18], [17:9], [8:0]. Little-endian order is the reverse.
- R4: With width code 2'b01 and `cfg_big_endian`=0, bits [17:0] are read first, then bits [35:18].
- R5: After either reset, `rd_empty`=1, `rd_almost_empty`=1, `wr_full`=0 and `rd_data`=0. A read while `rd_empty`=1 leaves `rd_data` and the buffer unchanged. A word stays counted until its last piece has been read.
- R6: `wr_full` rises once DEPTH words are held. Writes attempted while `wr_full`=1 store nothing.
- R7: `rd_almost_empty` is high when the word count seen by the read side is at or below the almost-empty offset.
- R8: `wr_almost_full` is high when the free space seen by the write side is at or below the almost-full offset.
- R9: `cfg_off_mode` is taken at full reset: 0 gives offsets of 8, 1 gives 16, 2 gives 64, and 3 loads `cfg_ae_level` and `cfg_af_level`.
- R10: A partial reset (`prst_n` low) empties the buffer and keeps the offsets, width and endian that were in place before it.
- R11: Changes to `cfg_width`, `cfg_big_endian`, `cfg_off_mode` and the level inputs while `mrst_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| mrst_n | input | 1 | Full reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, keeps settings |
| cfg_width | input | 2 | Read width code: 00 36-bit, 01 18-bit, 10 9-bit |
| cfg_big_endian | input | 1 | 1 sends the most significant piece first |
| cfg_off_mode | input | 2 | Offset choice taken at full reset |
| cfg_ae_level | input | $clog2(DEPTH)+1 | Almost-empty offset used when mode is 3 |
| cfg_af_level | input | $clog2(DEPTH)+1 | Almost-full offset used when mode is 3 |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write word |
| wr_full | output | 1 | Buffer holds DEPTH words |
| wr_almost_full | output | 1 | Free space at or below offset |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Read piece, zero-extended |
| rd_empty | output | 1 | No whole word is available |
| rd_almost_empty | output | 1 | Word count at or below offset |

## Verification
Write-side flags follow a write on the same `wr_clk` edge. The read side sees a new word only after the Gray-coded write pointer has passed through two `rd_clk` flops. That delay is two or three read edges, depending on phase. Read data is due on the edge that accepts the read. The monitor therefore drives `rd_en` on a falling edge, only when `rd_empty` is low at that moment, and compares `rd_data` with the head of the scoreboard queue on the next falling edge. Flag checks are sampled only after at least ten cycles of the other clock, so the pointer crossing has settled before any flag is judged.

// File: rtl/bmf_pkg.sv
// Package: shared encodings for the bus-matching FIFO.
package bmf_pkg;

    localparam int DATA_W = 36;

    // Read-port width codes (the value 2'b11 is folded to 36-bit)
    typedef enum logic [1:0] {
        BUS_W36 = 2'b00,
        BUS_W18 = 2'b01,
        BUS_W9  = 2'b10
    } bus_w_e;

    // Offset source chosen at full reset
    typedef enum logic [1:0] {
        OFF_8   = 2'b00,
        OFF_16  = 2'b01,
        OFF_64  = 2'b10,
        OFF_PAR = 2'b11
    } off_mode_e;

    // Preset level for the fixed offset modes
    function automatic int preset_level(input off_mode_e m);
        case (m)
            OFF_8:   return 8;
            OFF_16:  return 16;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/bmf_offset_cfg.sv
// Offset register: holds one threshold offset for one clock domain.
// Loads only while full reset is low. Partial reset does not touch it.
// Assumes mrst_n is held for several cycles of clk.
module bmf_offset_cfg
    import bmf_pkg::*;
#(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic [1:0]    mode,
    input  logic [PW-1:0] par_level,
    output logic [PW-1:0] level
);

    // Load the preset or parallel value during full reset
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            if (off_mode_e'(mode) == OFF_PAR)
                level <= par_level;
            else
                level <= PW'(preset_level(off_mode_e'(mode)));
        end
    end

    AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(level)); // R10

endmodule

// File: rtl/bmf_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock.
module bmf_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);

    logic [W-1:0] stage1;

    // Two register stages into the destination clock
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stage1   <= '0;
            gray_out <= '0;
        end else begin
            stage1   <= gray_in;
            gray_out <= stage1;
        end
    end

endmodule

// File: rtl/bmf_mem.sv
// Storage array: one write port on wr_clk, asynchronous read port.
// No reset; contents are only valid where the pointers say so.
module bmf_mem #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write one word per enabled edge
    always_ff @(posedge wclk) begin
        if (we)
            store[waddr] <= wdata;
    end

    // Read word at the read address
    assign rdata = store[raddr];

endmodule

// File: rtl/bmf_wr_ctl.sv
// Write-side control: write pointer, Gray copy for the read domain,
// full and almost-full flags from the synchronized read pointer.
// Assumes clr_n combines both reset inputs.
module bmf_wr_ctl #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        clr_n,
    input  logic        wr_en,
    input  logic [AW:0] rgray_sync,
    input  logic [AW:0] af_level,
    output logic        mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0] wgray,
    output logic        full,
    output logic        almost_full
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] free_sp;
    logic [PW-1:0] wbin_nx;

    // Convert the synchronized Gray read pointer to binary
    always_comb begin
        rbin_s[AW] = rgray_sync[AW];
        for (int i = AW - 1; i >= 0; i--)
            rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
    end

    // Occupancy and flags seen from the write side
    always_comb begin
        used        = wbin - rbin_s;
        free_sp     = PW'(DEPTH) - used;
        full        = (used == PW'(DEPTH));
        almost_full = (free_sp <= af_level);
        mem_we      = wr_en && !full;
        mem_waddr   = wbin[AW-1:0];
        wbin_nx     = wbin + 1'b1;
    end

    // Advance the write pointer on an accepted write
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!clr_n)
        (wr_en && full) |=> $stable(wgray)); // R6
    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> $onehot0(wgray ^ $past(wgray))); // R1
    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!clr_n)
        full |-> almost_full); // R8

endmodule

// File: rtl/bmf_rd_ctl.sv
// Read-side control: read pointer, piece counter, width/endian
// converter and empty / almost-empty flags. A word is released
// only after its last piece is read. Width and endian are latched
// during full reset only.
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          clr_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW:0]   ae_level,
    input  logic [1:0]    cfg_width,
    input  logic          cfg_big,
    output logic [AW-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          almost_empty
);

    localparam int PW = AW + 1;

    bus_w_e        width_q;
    logic          big_q;
    logic [1:0]    idx;
    logic [1:0]    last_idx;
    logic [1:0]    slot;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] used;
    logic [DATA_W-1:0] piece;
    logic [8:0]    lane  [4];
    logic [17:0]   half  [2];

    // Slice the word into 9-bit lanes and 18-bit halves
    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign lane[k] = mem_rdata[9*k +: 9];
    end
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = mem_rdata[18*h +: 18];
    end

    // Latch width and endian while full reset is held
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            width_q <= (cfg_width == 2'b11) ? BUS_W36 : bus_w_e'(cfg_width);
            big_q   <= cfg_big;
        end
    end

    // Convert the synchronized Gray write pointer to binary
    always_comb begin
        wbin_s[AW] = wgray_sync[AW];
        for (int i = AW - 1; i >= 0; i--)
            wbin_s[i] = wbin_s[i+1] ^ wgray_sync[i];
    end

    // Occupancy and flags seen from the read side
    always_comb begin
        used         = wbin_s - rbin;
        empty        = (used == '0);
        almost_empty = (used <= ae_level);
        mem_raddr    = rbin[AW-1:0];
        rbin_nx      = rbin + 1'b1;
    end

    // Pick the piece to present for the current index
    always_comb begin
        piece = '0;
        slot  = 2'd0;
        case (width_q)
            BUS_W18: begin
                last_idx = 2'd1;
                slot     = big_q ? {1'b0, ~idx[0]} : {1'b0, idx[0]};
                piece    = {18'b0, half[slot[0]]};
            end
            BUS_W9: begin
                last_idx = 2'd3;
                slot     = big_q ? (2'd3 - idx) : idx;
                piece    = {27'b0, lane[slot]};
            end
            default: begin
                last_idx = 2'd0;
                piece    = mem_rdata;
            end
        endcase
    end

    // Output a piece and move the pointer after the last piece
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            rbin    <= '0;
            rgray   <= '0;
            idx     <= '0;
            rd_data <= '0;
        end else if (rd_en && !empty) begin
            rd_data <= piece;
            if (idx == last_idx) begin
                idx   <= '0;
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!clr_n)
        (rd_en && empty) |=> ($stable(rd_data) && $stable(idx) && $stable(rgray))); // R5
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> ($stable(width_q) && $stable(big_q))); // R11
    AST_WIDE_NO_PIECES: assert property (@(posedge clk) disable iff (!clr_n)
        (width_q == BUS_W36) |-> (idx == 2'd0)); // R1
    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> $onehot0(rgray ^ $past(rgray))); // R1

endmodule

// File: rtl/bmf_top.sv
// Bus-matching dual-clock FIFO top: 36-bit write port, read port of
// 36/18/9 bits, Gray pointer crossing, threshold flags and two resets.
// Assumes both resets are held for several cycles of each clock.
module bmf_top
    import bmf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_big_endian,
    input  logic [1:0]        cfg_off_mode,
    input  logic [PW-1:0]     cfg_ae_level,
    input  logic [PW-1:0]     cfg_af_level,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_almost_empty
);

    logic            clr_n;
    logic            mem_we;
    logic [AW-1:0]   mem_waddr;
    logic [AW-1:0]   mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]   wgray, wgray_s;
    logic [PW-1:0]   rgray, rgray_s;
    logic [PW-1:0]   ae_lvl, af_lvl;

    // Either reset clears pointers and synchronizers
    assign clr_n = mrst_n & prst_n;

    bmf_offset_cfg #(.PW(PW)) u_af_cfg (
        .clk(wr_clk), .mrst_n(mrst_n), .mode(cfg_off_mode),
        .par_level(cfg_af_level), .level(af_lvl)
    );

    bmf_offset_cfg #(.PW(PW)) u_ae_cfg (
        .clk(rd_clk), .mrst_n(mrst_n), .mode(cfg_off_mode),
        .par_level(cfg_ae_level), .level(ae_lvl)
    );

    bmf_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .clr_n(clr_n), .gray_in(wgray), .gray_out(wgray_s)
    );

    bmf_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .clr_n(clr_n), .gray_in(rgray), .gray_out(rgray_s)
    );

    bmf_mem #(.AW(AW), .DW(DATA_W)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    bmf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .clr_n(clr_n), .wr_en(wr_en), .rgray_sync(rgray_s),
        .af_level(af_lvl), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wgray(wgray), .full(wr_full), .almost_full(wr_almost_full)
    );

    bmf_rd_ctl #(.AW(AW)) u_rd (
        .clk(rd_clk), .mrst_n(mrst_n), .clr_n(clr_n), .rd_en(rd_en),
        .wgray_sync(wgray_s), .ae_level(ae_lvl), .cfg_width(cfg_width),
        .cfg_big(cfg_big_endian), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .rd_data(rd_data), .rgray(rgray),
        .empty(rd_empty), .almost_empty(rd_almost_empty)
    );

endmodule

// File: tb/tb_bmf_top.sv
`timescale 1ns/1ps
module tb_bmf_top;

    localparam int DEPTH = 256;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic [1:0]    cfg_width = 2'b00;
    logic          cfg_big_endian = 1'b1;
    logic [1:0]    cfg_off_mode = 2'b00;
    logic [PW-1:0] cfg_ae_level = '0, cfg_af_level = '0;
    logic          wr_en = 1'b0;
    logic [35:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic          wr_full, wr_almost_full, rd_empty, rd_almost_empty;
    logic [35:0]   rd_data;

    int checks = 0, fails = 0;
    logic [35:0] exp_q [$];
    string       tag_q [$];
    int          mode_w = 0;
    bit          mode_big = 1'b1;
    bit          mon_en = 1'b0, rd_force = 1'b0, pend = 1'b0;
    int          wd = 0;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.0 rd_clk = ~rd_clk;   // unrelated read clock

    bmf_top #(.DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_width(cfg_width), .cfg_big_endian(cfg_big_endian),
        .cfg_off_mode(cfg_off_mode), .cfg_ae_level(cfg_ae_level),
        .cfg_af_level(cfg_af_level), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard driver: write one word and queue its expected pieces
    task automatic push_word(input logic [35:0] w, input string req);
        @(negedge wr_clk);
        while (wr_full) @(negedge wr_clk);
        wr_en = 1'b1; wr_data = w;
        case (mode_w)
            36: begin exp_q.push_back(w); tag_q.push_back(req); end
            18: for (int k = 0; k < 2; k++) begin
                    int s = mode_big ? 1 - k : k;
                    exp_q.push_back({18'b0, w[18*s +: 18]}); tag_q.push_back(req);
                end
            default: for (int k = 0; k < 4; k++) begin
                    int s = mode_big ? 3 - k : k;
                    exp_q.push_back({27'b0, w[9*s +: 9]}); tag_q.push_back(req);
                end
        endcase
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Scoreboard monitor: read when data is available, compare next cycle
    always @(negedge rd_clk) begin
        if (pend) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6: unexpected read data actual %h expected none", rd_data);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
        pend  = mon_en && !rd_empty;
        rd_en = mon_en ? !rd_empty : rd_force;
    end

    task automatic full_reset(input int w, input bit big, input logic [1:0] om,
                              input int ae, input int af);
        mon_en = 1'b0;
        repeat (4) @(negedge rd_clk);
        cfg_width = (w == 36) ? 2'b00 : (w == 18) ? 2'b01 : 2'b10;
        cfg_big_endian = big; cfg_off_mode = om;
        cfg_ae_level = PW'(ae); cfg_af_level = PW'(af);
        mrst_n = 1'b0;
        repeat (8) @(negedge wr_clk);
        mrst_n = 1'b1;
        mode_w = w; mode_big = big;
        exp_q.delete(); tag_q.delete();
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic drain();
        mon_en = 1'b1;
        for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge rd_clk);
        repeat (12) @(negedge rd_clk);
        mon_en = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk("R5 empty after drain", {35'b0, rd_empty}, 36'd1);
    endtask

    function automatic logic [35:0] word(input int i);
        return {4'hC, 32'(i * 32'h0103_0507 + 32'h1F2E_3D4C)};
    endfunction

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        repeat (10) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge wr_clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected finish", wd);
            summary();
            $finish;
        end
    end

    initial begin
        // R5, R9: full reset, 36-bit big-endian, offsets 8
        full_reset(36, 1'b1, 2'b00, 0, 0);
        chk("R5 reset empty", {35'b0, rd_empty}, 36'd1);
        chk("R5 reset almost empty", {35'b0, rd_almost_empty}, 36'd1);
        chk("R5 reset not full", {35'b0, wr_full}, 36'd0);
        chk("R5 reset data", rd_data, 36'd0);
        // R5: read while empty is ignored
        rd_force = 1'b1;
        repeat (5) @(negedge rd_clk);
        rd_force = 1'b0;
        @(negedge rd_clk);
        chk("R5 read when empty data", rd_data, 36'd0);
        chk("R5 read when empty flag", {35'b0, rd_empty}, 36'd1);

        // R7 / R11: offset 8, settings changed with no reset
        cfg_width = 2'b10; cfg_big_endian = 1'b0; cfg_off_mode = 2'b10;
        for (int i = 0; i < 8; i++) push_word(word(i), "R11");
        settle();
        chk("R7 count 8 ae", {35'b0, rd_almost_empty}, 36'd1);
        push_word(word(8), "R11");
        settle();
        chk("R7 count 9 not ae", {35'b0, rd_almost_empty}, 36'd0);
        for (int i = 9; i < 20; i++) push_word(word(i), "R1");
        drain();

        // R6 / R8: fill to DEPTH, writes while full ignored
        for (int i = 0; i < DEPTH - 9; i++) push_word(word(100 + i), "R6");
        @(negedge wr_clk);
        chk("R8 free 9 not af", {35'b0, wr_almost_full}, 36'd0);
        push_word(word(999), "R6");
        @(negedge wr_clk);
        chk("R8 free 8 af", {35'b0, wr_almost_full}, 36'd1);
        for (int i = 0; i < 8; i++) push_word(word(500 + i), "R6");
        @(negedge wr_clk);
        chk("R6 full", {35'b0, wr_full}, 36'd1);
        wr_en = 1'b1; wr_data = 36'hBAD_BAD_BA;
        repeat (3) @(negedge wr_clk);
        wr_en = 1'b0;
        drain();

        // R2, R9: 18-bit big-endian, offset 16
        full_reset(18, 1'b1, 2'b01, 0, 0);
        for (int i = 0; i < 16; i++) push_word(word(40 + i), "R2");
        settle();
        chk("R9 mode1 count 16 ae", {35'b0, rd_almost_empty}, 36'd1);
        push_word(word(60), "R2");
        settle();
        chk("R9 mode1 count 17 not ae", {35'b0, rd_almost_empty}, 36'd0);
        drain();

        // R4: 18-bit little-endian
        full_reset(18, 1'b0, 2'b00, 0, 0);
        for (int i = 0; i < 12; i++) push_word(word(70 + i), "R4");
        drain();

        // R3, R9: 9-bit big-endian, parallel levels 5 / 10
        full_reset(9, 1'b1, 2'b11, 5, 10);
        for (int i = 0; i < 5; i++) push_word(word(90 + i), "R3");
        settle();
        chk("R9 par count 5 ae", {35'b0, rd_almost_empty}, 36'd1);
        push_word(word(95), "R3");
        settle();
        chk("R9 par count 6 not ae", {35'b0, rd_almost_empty}, 36'd0);
        drain();

        // R10: partial reset empties, keeps 9-bit big and level 5
        for (int i = 0; i < 3; i++) push_word(word(120 + i), "R10");
        settle();
        cfg_width = 2'b00; cfg_big_endian = 1'b0; cfg_off_mode = 2'b00;
        prst_n = 1'b0;
        repeat (8) @(negedge wr_clk);
        prst_n = 1'b1;
        exp_q.delete(); tag_q.delete();
        settle();
        chk("R10 empty after partial", {35'b0, rd_empty}, 36'd1);
        chk("R10 data cleared", rd_data, 36'd0);
        for (int i = 0; i < 5; i++) push_word(word(130 + i), "R10");
        settle();
        chk("R10 level kept count 5", {35'b0, rd_almost_empty}, 36'd1);
        push_word(word(135), "R10");
        settle();
        chk("R10 level kept count 6", {35'b0, rd_almost_empty}, 36'd0);
        drain();

        // R3, R9: 9-bit little-endian, offset 64
        full_reset(9, 1'b0, 2'b10, 0, 0);
        for (int i = 0; i < 64; i++) push_word(word(200 + i), "R3");
        settle();
        chk("R9 mode2 count 64 ae", {35'b0, rd_almost_empty}, 36'd1);
        push_word(word(300), "R3");
        settle();
        chk("R9 mode2 count 65 not ae", {35'b0, rd_almost_empty}, 36'd0);
        drain();

        summary();
        $finish;
    end

endmodule